// File: doc/BRIEF.md
# Split-Index Physically Tagged Data Cache

This block is a first-level data cache that picks its set from the untranslated address while the address translation runs next to it. The processor side offers one 32-bit load or store at a time on a valid/ready request channel. A translation input supplies the physical frame number one cycle after the request is accepted. The cache then decides hit or miss by comparing that frame number against the per-line physical tags. The default array is 16 kB: two ways of 256 sets, 32-byte lines, 4 kB pages. Each line holds a valid bit, a dirty bit and a 20-bit physical tag. Stores are write-back with write-allocate. A dirty line is written to memory before its slot is reused.

The set index spans address bits 12:5. Bit 12 lies above the page offset, so one physical line can be reached through two different sets. When the virtual and physical copies of bit 12 differ, the cache raises a synonym flag. It then probes the set that the physical address would select. A copy of the same physical line found there is written back if dirty and is then invalidated, and only after that is the access served. A flush request walks every line, writes back the dirty ones, clears all valid bits and pulses a done signal.

Back-pressure rules are these. A request must hold its fields until `req_ready` is seen high at a clock edge. `req_ready` stays low from acceptance until the access completes. The memory request holds its address and direction until `mem_req_ready`. Each write-back beat holds `mem_wdata` stable until `mem_wready`. Read beats are taken only while `mem_rready` is high. The response has no ready and lasts one cycle.

Top module: `vipt_dcache`

## Requirements
- R1: A load that hits returns the stored word with `rsp_valid` high for exactly one cycle, in the second cycle after the cycle in which the request was accepted, and issues no memory request.
- R2: The set is chosen by virtual address bits 12:5 (`req_vword[10:3]`), and a line hits only when it is valid and its stored tag equals the frame number `xl_pfn` sampled in the cycle after acceptance; the same virtual address with a different frame number misses.
- R3: A load miss issues one memory read at physical line address {frame number, virtual bits 11:5, 5'b0}, takes 8 sequential 32-bit beats (beat k is the word at byte offset 4k), and then answers with the requested word.
- R4: A store that hits replaces the addressed word and marks the line dirty without any memory traffic; a later load of that word returns the stored value.
- R5: A store miss first fills the whole line from memory and then merges the store word; the other words of the line keep their memory values.
- R6: On a miss, an invalid way of the set is used if there is one; otherwise the way not used most recently in that set is replaced.
- R7: A dirty victim is written back as 8 beats to its own physical line address, {its tag, index bits 6:0, 5'b0}, before the fill read is requested.
- R8: `syn_hit` is high in the cycle after acceptance exactly when virtual address bit 12 differs from frame number bit 0 (physical bit 12), and low otherwise.
- R9: On a synonym, a line in the set indexed by {frame bit 0, virtual bits 11:5} whose tag matches is written back first if dirty, and is then invalidated before the access is served.
- R10: A one-cycle `flush_req` while idle writes back every dirty line, clears every valid bit and then pulses `flush_done` for one cycle; later accesses miss.
- R11: `req_ready` is low from the cycle after acceptance until the access or flush completes.
- R12: After reset every line is invalid, `req_ready` is high and `rsp_valid` and `flush_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vword | input | 11 | Virtual address bits 12:2 (word address inside the index span) |
| req_wdata | input | 32 | Store data |
| xl_pfn | input | 20 | Physical frame number, valid the cycle after acceptance |
| rsp_valid | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| syn_hit | output | 1 | Synonym flag for the current access |
| mem_req_valid | output | 1 | Memory line request valid |
| mem_req_ready | input | 1 | Memory accepts the line request |
| mem_req_we | output | 1 | 1 = write-back, 0 = fill |
| mem_req_addr | output | 32 | Physical line address |
| mem_wvalid | output | 1 | Write-back beat valid |
| mem_wready | input | 1 | Memory takes the write-back beat |
| mem_wdata | output | 32 | Write-back beat data |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rready | output | 1 | Cache takes the fill beat |
| mem_rdata | input | 32 | Fill beat data |
| flush_req | input | 1 | Start a flush walk |
| flush_done | output | 1 | Flush finished, one-cycle pulse |

## Verification
A hit is answered in the second cycle after the accepting edge, and the synonym flag and the low `req_ready` both appear in the first cycle after it. The bench drives all inputs and reads all outputs on the falling edge. It counts falling edges from acceptance and requires exactly two for every hit. Misses, write-backs and flushes depend on the memory model's pace, so the bench waits for `rsp_valid` or `flush_done` under a cycle limit. It then checks the logged memory traffic: the number of reads and write-backs, their addresses, which came first, and the words written back.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_XLATE,
    ST_ALIAS,
    ST_TAG,
    ST_WB_REQ,
    ST_WB_DAT,
    ST_FILL_REQ,
    ST_FILL_DAT,
    ST_FLUSH
  } vc_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_set,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0]            rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic [WAY_W-1:0]           rd_lru,
  input  logic                       wr_en,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [IDX_W-1:0]           wr_set,
  input  logic                       wr_valid,
  input  logic                       wr_dirty,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       lru_en,
  input  logic [IDX_W-1:0]           lru_set,
  input  logic [WAY_W-1:0]           lru_val
);
  logic [WAY_W-1:0] lru_q [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vbits;
    logic [SETS-1:0]  dbits;
    logic [TAG_W-1:0] tags [SETS];
    logic             sel;
    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vbits <= '0;
        dbits <= '0;
      end else if (sel) begin
        vbits[wr_set] <= wr_valid;
        dbits[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tags[wr_set] <= wr_tag;
    end

    assign rd_valid[w] = vbits[rd_set];
    assign rd_dirty[w] = dbits[rd_set];
    assign rd_tag[w]   = tags[rd_set];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (lru_en) begin
      lru_q[lru_set] <= lru_val;
    end
  end

  assign rd_lru = lru_q[rd_set];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dirty) |-> wr_valid); // R4
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 256,
  parameter int LINE_W = 256,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic [IDX_W-1:0]            rd_set,
  output logic [WAYS-1:0][LINE_W-1:0] rd_line,
  input  logic                        wr_en,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic [LINE_W-1:0]           wr_line
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] lines [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) lines[wr_set] <= wr_line;
    end
    assign rd_line[w] = lines[rd_set];
  end
endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           cmp_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       free_any,
  output logic [WAY_W-1:0]           free_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == cmp_tag);
  end

  assign hit      = |hit_vec;
  assign free_any = ~&valid;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way  = WAY_W'(w);
      if (!valid[w])  free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 256,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 8,
  parameter int PAGE_BITS  = 12,
  localparam int BYTE_W  = $clog2(DATA_W / 8),
  localparam int WORD_W  = $clog2(LINE_WORDS),
  localparam int OFF_W   = BYTE_W + WORD_W,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - PAGE_BITS,
  localparam int SYN_W   = OFF_W + IDX_W - PAGE_BITS,
  localparam int VW_W    = IDX_W + WORD_W,
  localparam int LINE_W  = DATA_W * LINE_WORDS,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int FLC_W   = IDX_W + WAY_W,
  localparam int INPG_W  = PAGE_BITS - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [VW_W-1:0]   req_vword,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  xl_pfn,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              syn_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  output logic              mem_rready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              flush_req,
  output logic              flush_done
);
  typedef logic [LINE_WORDS-1:0][DATA_W-1:0] line_t;

  vc_state_e state_q, state_d, ret_q;
  logic [VW_W-1:0]   va_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [TAG_W-1:0]  pfn_q;
  logic [WORD_W-1:0] beat_q;
  logic [IDX_W-1:0]  wb_set_q;
  logic [WAY_W-1:0]  wb_way_q, fill_way_q;
  logic [LINE_WORDS-2:0][DATA_W-1:0] fbuf_q;
  logic [FLC_W-1:0]  fl_cnt_q;
  logic              done_q;

  logic [IDX_W-1:0]  v_idx, p_idx, rd_set, fl_set;
  logic [WORD_W-1:0] w_sel;
  logic [WAY_W-1:0]  fl_way;

  logic [WAYS-1:0]             t_valid, t_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0]  t_tag;
  logic [WAYS-1:0][LINE_W-1:0] d_line;
  logic [WAY_W-1:0]            t_lru, hit_way, free_way, victim;
  logic                        hit, free_any, vic_dirty, fl_dirty;

  logic              tw_en, tw_valid, tw_dirty, lru_en, dw_en;
  logic [WAY_W-1:0]  tw_way, dw_way;
  logic [IDX_W-1:0]  tw_set;
  logic [TAG_W-1:0]  tw_tag;
  line_t             hit_line, wb_line, merged, fill_line, dw_line;
  logic              beat_last, wb_go_tag, wb_go_miss, wb_go_fl, fl_last;

  assign v_idx  = va_q[WORD_W +: IDX_W];
  assign p_idx  = {pfn_q[SYN_W-1:0], va_q[WORD_W +: INPG_W]};
  assign w_sel  = va_q[WORD_W-1:0];
  assign fl_set = fl_cnt_q[WAY_W +: IDX_W];
  assign fl_way = fl_cnt_q[WAY_W-1:0];

  always_comb begin
    case (state_q)
      ST_ALIAS:             rd_set = p_idx;
      ST_FLUSH:             rd_set = fl_set;
      ST_WB_REQ, ST_WB_DAT: rd_set = wb_set_q;
      default:              rd_set = v_idx;
    endcase
  end

  vipt_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_set(rd_set),
    .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tag(t_tag), .rd_lru(t_lru),
    .wr_en(tw_en), .wr_way(tw_way), .wr_set(tw_set), .wr_valid(tw_valid),
    .wr_dirty(tw_dirty), .wr_tag(tw_tag),
    .lru_en(lru_en), .lru_set(v_idx), .lru_val(~hit_way)
  );

  vipt_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rd_set(rd_set), .rd_line(d_line),
    .wr_en(dw_en), .wr_way(dw_way), .wr_set(v_idx), .wr_line(dw_line)
  );

  vipt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid(t_valid), .tags(t_tag), .cmp_tag(pfn_q),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way),
    .free_any(free_any), .free_way(free_way)
  );

  assign victim    = free_any ? free_way : t_lru;
  assign vic_dirty = t_valid[victim] && t_dirty[victim];
  assign fl_dirty  = t_valid[fl_way] && t_dirty[fl_way];
  assign hit_line  = d_line[hit_way];
  assign wb_line   = d_line[wb_way_q];
  assign fill_line = {mem_rdata, fbuf_q};
  assign beat_last = (beat_q == WORD_W'(LINE_WORDS - 1));
  assign fl_last   = (fl_cnt_q == '1);

  always_comb begin
    merged        = hit_line;
    merged[w_sel] = wd_q;
  end

  assign wb_go_tag  = (state_q == ST_ALIAS) && hit && t_dirty[hit_way];
  assign wb_go_miss = (state_q == ST_TAG) && !hit && vic_dirty;
  assign wb_go_fl   = (state_q == ST_FLUSH) && fl_dirty;

  assign req_ready     = (state_q == ST_IDLE) && !flush_req;
  assign syn_hit       = (state_q == ST_XLATE) &&
                         (va_q[WORD_W + INPG_W +: SYN_W] != xl_pfn[SYN_W-1:0]);
  assign rsp_valid     = (state_q == ST_TAG) && hit;
  assign rsp_rdata     = hit_line[w_sel];
  assign mem_req_valid = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
  assign mem_req_we    = (state_q == ST_WB_REQ);
  assign mem_req_addr  = (state_q == ST_WB_REQ)
                       ? {t_tag[wb_way_q], wb_set_q[INPG_W-1:0], OFF_W'(0)}
                       : {pfn_q, va_q[WORD_W +: INPG_W], OFF_W'(0)};
  assign mem_wvalid    = (state_q == ST_WB_DAT);
  assign mem_wdata     = wb_line[beat_q];
  assign mem_rready    = (state_q == ST_FILL_DAT);
  assign flush_done    = done_q;

  always_comb begin
    state_d  = state_q;
    tw_en    = 1'b0;
    tw_way   = hit_way;
    tw_set   = rd_set;
    tw_valid = 1'b0;
    tw_dirty = 1'b0;
    tw_tag   = pfn_q;
    lru_en   = 1'b0;
    dw_en    = 1'b0;
    dw_way   = hit_way;
    dw_line  = merged;
    case (state_q)
      ST_IDLE: begin
        if (flush_req)      state_d = ST_FLUSH;
        else if (req_valid) state_d = ST_XLATE;
      end
      ST_XLATE: state_d = syn_hit ? ST_ALIAS : ST_TAG;
      ST_ALIAS: begin
        if (wb_go_tag) state_d = ST_WB_REQ;
        else begin
          tw_en   = hit;
          state_d = ST_TAG;
        end
      end
      ST_TAG: begin
        if (hit) begin
          lru_en   = 1'b1;
          tw_en    = we_q;
          tw_valid = 1'b1;
          tw_dirty = 1'b1;
          dw_en    = we_q;
          state_d  = ST_IDLE;
        end else begin
          state_d = vic_dirty ? ST_WB_REQ : ST_FILL_REQ;
        end
      end
      ST_WB_REQ: if (mem_req_ready) state_d = ST_WB_DAT;
      ST_WB_DAT: begin
        if (mem_wready && beat_last) begin
          tw_en   = 1'b1;
          tw_way  = wb_way_q;
          tw_tag  = t_tag[wb_way_q];
          state_d = ret_q;
        end
      end
      ST_FILL_REQ: if (mem_req_ready) state_d = ST_FILL_DAT;
      ST_FILL_DAT: begin
        if (mem_rvalid && beat_last) begin
          tw_en    = 1'b1;
          tw_way   = fill_way_q;
          tw_set   = v_idx;
          tw_valid = 1'b1;
          dw_en    = 1'b1;
          dw_way   = fill_way_q;
          dw_line  = fill_line;
          state_d  = ST_TAG;
        end
      end
      ST_FLUSH: begin
        if (fl_dirty) state_d = ST_WB_REQ;
        else begin
          tw_en   = 1'b1;
          tw_way  = fl_way;
          tw_tag  = t_tag[fl_way];
          if (fl_last) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ret_q      <= ST_IDLE;
      va_q       <= '0;
      we_q       <= 1'b0;
      wd_q       <= '0;
      pfn_q      <= '0;
      beat_q     <= '0;
      wb_set_q   <= '0;
      wb_way_q   <= '0;
      fill_way_q <= '0;
      fbuf_q     <= '0;
      fl_cnt_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FLUSH) && !fl_dirty && fl_last;
      if (req_valid && req_ready) begin
        va_q <= req_vword;
        we_q <= req_we;
        wd_q <= req_wdata;
      end
      if (state_q == ST_IDLE && flush_req) fl_cnt_q <= '0;
      if (state_q == ST_FLUSH && !fl_dirty) fl_cnt_q <= fl_cnt_q + 1'b1;
      if (state_q == ST_XLATE) pfn_q <= xl_pfn;
      if (wb_go_tag) begin
        wb_set_q <= p_idx;
        wb_way_q <= hit_way;
        ret_q    <= ST_TAG;
      end
      if (state_q == ST_TAG && !hit) begin
        fill_way_q <= victim;
        wb_set_q   <= v_idx;
        wb_way_q   <= victim;
        ret_q      <= ST_FILL_REQ;
      end
      if (wb_go_fl) begin
        wb_set_q <= fl_set;
        wb_way_q <= fl_way;
        ret_q    <= ST_FLUSH;
      end
      if ((mem_wvalid && mem_wready) || (mem_rready && mem_rvalid))
        beat_q <= beat_q + 1'b1;
      if (mem_rready && mem_rvalid)
        fbuf_q <= {mem_rdata, fbuf_q[LINE_WORDS-2:1]};
    end
  end

  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R1
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAG) |-> $onehot0(hit_vec)); // R2
  AST_SYN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    syn_hit |=> !rsp_valid); // R9
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done); // R10
endmodule

// File: tb/vipt_dcache_bench.sv
module vipt_dcache_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic        req_ready;
  logic [10:0] req_vword = '0;
  logic [31:0] req_wdata = '0;
  logic [19:0] xl_pfn = '0;
  logic        rsp_valid, syn_hit;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_wvalid;
  logic        mem_wready = 1'b1;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic        mem_rready;
  logic [31:0] mem_rdata = '0;
  logic        flush_req = 1'b0;
  logic        flush_done;

  int n_checks = 0;
  int n_fail   = 0;
  int n_rd = 0, n_wb = 0, first_we = -1;
  logic [31:0] last_rd = '0, last_wb = '0;
  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vipt_dcache u_vipt_dcache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_vword(req_vword), .req_wdata(req_wdata), .xl_pfn(xl_pfn),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .syn_hit(syn_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata),
    .flush_req(flush_req), .flush_done(flush_done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hC0DE_0000 ^ a;
  endfunction

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return pat(a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_rd = 0; n_wb = 0; first_we = -1;
  endtask

  // memory model: accepts requests at once, streams 8 beats
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        if (first_we < 0) first_we = mem_req_we ? 1 : 0;
        if (mem_req_we) begin
          int n;
          n_wb++; last_wb = a; n = 0;
          while (n < 8) begin
            @(negedge clk);
            if (mem_wvalid) begin
              mem[a + 32'(4 * n)] = mem_wdata;
              n++;
            end
          end
        end else begin
          n_rd++; last_rd = a;
          for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata  = rdm(a + 32'(4 * b));
          end
          @(negedge clk);
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  task automatic op(input logic we, input logic [31:0] va, input logic [31:0] wd,
                    input logic [19:0] pfn, output logic [31:0] rd, output int lat,
                    output logic syn, output logic rdy_busy);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_vword = va[12:2]; req_wdata = wd; xl_pfn = pfn;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    syn = syn_hit; rdy_busy = req_ready; lat = 1;
    while (!rsp_valid && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  task automatic t_reset();
    check("R12 req_ready after reset", 32'(req_ready), 1);
    check("R12 rsp_valid after reset", 32'(rsp_valid), 0);
    check("R12 flush_done after reset", 32'(flush_done), 0);
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(0, 32'h40, 0, 20'h2, rd, lat, syn, rb);
    check("R3 miss data", rd, pat(32'h2040));
    check("R12 first access misses", 32'(n_rd), 1);
    check("R3 fill address", last_rd, 32'h2040);
    check("R8 no synonym flag", 32'(syn), 0);
    check("R11 ready low while busy", 32'(rb), 0);
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(0, 32'h40, 0, 20'h2, rd, lat, syn, rb);
    check("R1 hit latency", 32'(lat), 2);
    check("R1 hit data", rd, pat(32'h2040));
    check("R1 no memory traffic", 32'(n_rd + n_wb), 0);
  endtask

  task automatic t_store_hit();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(1, 32'h44, 32'h1111_2222, 20'h2, rd, lat, syn, rb);
    check("R4 store hit latency", 32'(lat), 2);
    op(0, 32'h44, 0, 20'h2, rd, lat, syn, rb);
    check("R4 load after store", rd, 32'h1111_2222);
    check("R4 no memory traffic", 32'(n_rd + n_wb), 0);
    check("R4 memory untouched", rdm(32'h2044), pat(32'h2044));
  endtask

  task automatic t_tag_mismatch();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(0, 32'h40, 0, 20'h0, rd, lat, syn, rb);
    check("R2 other frame misses", 32'(n_rd), 1);
    check("R2 other frame data", rd, pat(32'h0040));
    check("R6 free way used, no eviction", 32'(n_wb), 0);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(0, 32'h40, 0, 20'h4, rd, lat, syn, rb);
    check("R7 one write-back", 32'(n_wb), 1);
    check("R7 write-back address", last_wb, 32'h2040);
    check("R7 written-back word", rdm(32'h2044), 32'h1111_2222);
    check("R7 write-back before fill", 32'(first_we), 1);
    check("R3 fill after eviction", last_rd, 32'h4040);
    check("R3 data after eviction", rd, pat(32'h4040));
    clear_log();
    op(0, 32'h40, 0, 20'h0, rd, lat, syn, rb);
    check("R6 recent way kept", 32'(lat), 2);
  endtask

  task automatic t_store_miss();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(1, 32'h80, 32'hE0E0_0606, 20'h6, rd, lat, syn, rb);
    check("R5 allocate fill", 32'(n_rd), 1);
    check("R5 fill address", last_rd, 32'h6080);
    op(0, 32'h80, 0, 20'h6, rd, lat, syn, rb);
    check("R5 merged word", rd, 32'hE0E0_0606);
    op(0, 32'h84, 0, 20'h6, rd, lat, syn, rb);
    check("R5 neighbour word", rd, pat(32'h6084));
  endtask

  task automatic t_syn_clean();
    logic [31:0] rd; int lat; logic syn, rb;
    clear_log();
    op(0, 32'h1040, 0, 20'h4, rd, lat, syn, rb);
    check("R8 synonym flag", 32'(syn), 1);
    check("R9 clean alias no write-back", 32'(n_wb), 0);
    check("R9 data via synonym", rd, pat(32'h4040));
    clear_log();
    op(0, 32'h40, 0, 20'h4, rd, lat, syn, rb);
    check("R9 alias line invalidated", 32'(n_rd), 1);
  endtask

  task automatic t_syn_dirty();
    logic [31:0] rd; int lat; logic syn, rb;
    op(1, 32'h1080, 32'h7777_0001, 20'h7, rd, lat, syn, rb);
    check("R8 equal bit no flag", 32'(syn), 0);
    clear_log();
    op(0, 32'h0080, 0, 20'h7, rd, lat, syn, rb);
    check("R8 synonym flag dirty", 32'(syn), 1);
    check("R9 dirty alias written back", 32'(n_wb), 1);
    check("R9 alias write-back address", last_wb, 32'h7080);
    check("R9 alias data in memory", rdm(32'h7080), 32'h7777_0001);
    check("R9 load sees store", rd, 32'h7777_0001);
  endtask

  task automatic t_flush();
    logic [31:0] rd; int lat; logic syn, rb; int w;
    clear_log();
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    check("R11 ready low during flush", 32'(req_ready), 0);
    w = 0;
    while (!flush_done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    check("R10 flush done", 32'(flush_done), 1);
    check("R10 dirty lines written", 32'(n_wb), 1);
    check("R10 flushed data", rdm(32'h6080), 32'hE0E0_0606);
    clear_log();
    op(0, 32'h80, 0, 20'h6, rd, lat, syn, rb);
    check("R10 miss after flush", 32'(n_rd), 1);
    check("R10 data after flush", rd, 32'hE0E0_0606);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_store_hit();
    t_tag_mismatch();
    t_dirty_evict();
    t_store_miss();
    t_syn_clean();
    t_syn_dirty();
    t_flush();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule